// File: doc/BRIEF.md
# Three-Wire Staged Serial Control Register

This block takes control words from a host over a three-wire serial bus (frame enable, data, serial clock) and turns them into the static settings of a frequency synthesizer. Bits are taken on falling serial-clock edges while the enable is high. The first bit of a frame is bit 1. The bus pins are brought into the single system clock domain through two-flop synchronisers. Falling edges are detected on the synchronised serial clock.

A frame commits in stages, triggered by the count of accepted bits. After 4 bits the four band-select outputs load. After 19 bits the 10-bit main count and 5-bit swallow count load together. After 27 bits the configuration fields load: charge-pump current, test mode, reference ratio select and tuning-amplifier disable. A short frame therefore updates only the groups whose commit point it reached. The rest of its bits are dropped. Each rising edge of the enable restarts the bit count. A full frame whose first configuration bit (the mandatory-one bit) is 0 is rejected for the configuration group only, and it sets a sticky error flag.

Top module: `tw_cfg_reg`

## Requirements
- R1: After reset the outputs are as follows: band_o=0, main_cnt_o=0, swal_cnt_o=0, cp_hi_o=1 (high current), test_mode_o=3'b010 (charge pump off), ref_sel_o=2'b00 (1/640 ratio), amp_off_o=1 and cfg_err_o=0.
- R2: Falling serial-clock edges that occur while the enable is low change no output.
- R3: On the 4th accepted bit, band_o loads the first four bits of the frame. Bit 1 goes to band_o[3] and bit 4 goes to band_o[0].
- R4: On the 19th accepted bit, main_cnt_o loads bits 5..14 (bit 5 is the MSB) and swallow count swal_cnt_o loads bits 15..19 (bit 15 is the MSB). Both load in the same cycle.
- R5: If the enable falls before the 19th bit, only band_o may have changed. The main and swallow counts keep their old values.
- R6: Each 19th-bit commit sets ref_sel_o to 2'b00.
- R7: On the 27th accepted bit, bits 20..27 are read as follows. Bit 20 is the mandatory-one bit. Bit 21 goes to cp_hi_o. Bits 22..24 go to test_mode_o[2:0], with bit 22 as the MSB. Bits 25..26 go to ref_sel_o[1:0], with bit 25 as the MSB. Bit 27 goes to amp_off_o. These fields load only if bit 20 is 1.
- R8: Falling edges after the 27th bit of a frame change no output.
- R9: If bit 20 of a 27-bit frame is 0, the band and divider groups still commit, but the configuration fields keep their old values and cfg_err_o goes to 1. cfg_err_o then stays at 1 until reset.
- R10: A rising edge of the enable restarts the bit count, so the bits left over from an earlier frame never count toward a later frame's commit points.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_en_i | input | 1 | Frame enable, high during a frame |
| ser_dat_i | input | 1 | Serial data |
| ser_clk_i | input | 1 | Serial clock; data taken on its falling edge |
| band_o | output | 4 | Band-select enables |
| main_cnt_o | output | 10 | Main divider count |
| swal_cnt_o | output | 5 | Swallow divider count |
| cp_hi_o | output | 1 | Charge-pump high-current select |
| test_mode_o | output | 3 | Test-mode field |
| ref_sel_o | output | 2 | Reference ratio select |
| amp_off_o | output | 1 | Tuning amplifier disable |
| cfg_err_o | output | 1 | Sticky flag for a rejected configuration group |

## Verification
The frames used have lengths 2, 4, 12, 19, 27 and 27 followed by extra edges. Comparing them separates the three commit points from one another and from the "beyond the end" case. One full frame carries a zero mandatory-one bit. This shows that the configuration group is rejected while the earlier groups still commit. A 2-bit frame followed at once by a 4-bit frame shows whether the count restarts on each enable. Serial-clock pulses sent with the enable low show that idle bus traffic is ignored.

// File: rtl/tw_cfg_pkg.sv
package tw_cfg_pkg;
  localparam int BAND_W = 4;
  localparam int MAIN_W = 10;
  localparam int SWAL_W = 5;
  localparam int TEST_W = 8;
  localparam int DIV_W  = MAIN_W + SWAL_W;
  localparam int DIV_END   = BAND_W + DIV_W;
  localparam int FRAME_LEN = DIV_END + TEST_W;
  localparam int CNT_W  = $clog2(FRAME_LEN + 1);

  typedef struct packed {
    logic       cp_hi;
    logic [2:0] test_mode;
    logic [1:0] ref_sel;
    logic       amp_off;
  } cfg_t;

  localparam cfg_t CFG_RST = '{cp_hi: 1'b1, test_mode: 3'b010,
                               ref_sel: 2'b00, amp_off: 1'b1};
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [1:0] st;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st <= 2'b00;
      else         st <= {st[0], d_i[g]};
    end
    assign q_o[g] = st[1];
  end
endmodule

// File: rtl/tw_frame_rx.sv
module tw_frame_rx
  import tw_cfg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_s_i,
  input  logic             dat_s_i,
  input  logic             sclk_s_i,
  output logic             fall_o,
  output logic [DIV_W-1:0] sh_nxt_o,
  output logic             band_stb_o,
  output logic             div_stb_o,
  output logic             tst_stb_o
);
  logic             sclk_q, en_q;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic [DIV_W-2:0] sh;
  logic             take, en_rise;

  assign fall_o   = sclk_q & ~sclk_s_i;
  assign en_rise  = en_s_i & ~en_q;
  // stop counting once the frame is complete
  assign take     = fall_o & en_s_i & (cnt != CNT_W'(FRAME_LEN));
  assign cnt_nxt  = cnt + 1'b1;
  assign sh_nxt_o = {sh, dat_s_i};

  assign band_stb_o = take & (cnt_nxt == CNT_W'(BAND_W));
  assign div_stb_o  = take & (cnt_nxt == CNT_W'(DIV_END));
  assign tst_stb_o  = take & (cnt_nxt == CNT_W'(FRAME_LEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      en_q   <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
    end else begin
      sclk_q <= sclk_s_i;
      en_q   <= en_s_i;
      if (en_rise) begin
        cnt <= '0;
      end else if (take) begin
        cnt <= cnt_nxt;
        sh  <= sh_nxt_o[DIV_W-2:0];
      end
    end
  end
endmodule

// File: rtl/tw_cfg_latch.sv
module tw_cfg_latch
  import tw_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  sh_nxt_i,
  input  logic              band_stb_i,
  input  logic              div_stb_i,
  input  logic              tst_stb_i,
  output logic [BAND_W-1:0] band_o,
  output logic [MAIN_W-1:0] main_o,
  output logic [SWAL_W-1:0] swal_o,
  output cfg_t              cfg_o,
  output logic              err_o
);
  logic si_ok;
  assign si_ok = sh_nxt_i[TEST_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      band_o <= '0;
      main_o <= '0;
      swal_o <= '0;
      cfg_o  <= CFG_RST;
      err_o  <= 1'b0;
    end else begin
      if (band_stb_i) band_o <= sh_nxt_i[BAND_W-1:0];
      if (div_stb_i) begin
        main_o        <= sh_nxt_i[SWAL_W +: MAIN_W];
        swal_o        <= sh_nxt_i[SWAL_W-1:0];
        cfg_o.ref_sel <= 2'b00;  // short frame implies 1/640
      end
      if (tst_stb_i) begin
        if (si_ok) cfg_o <= cfg_t'(sh_nxt_i[TEST_W-2:0]);
        else       err_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tw_cfg_reg.sv
module tw_cfg_reg
  import tw_cfg_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ser_en_i,
  input  logic        ser_dat_i,
  input  logic        ser_clk_i,
  output logic [3:0]  band_o,
  output logic [9:0]  main_cnt_o,
  output logic [4:0]  swal_cnt_o,
  output logic        cp_hi_o,
  output logic [2:0]  test_mode_o,
  output logic [1:0]  ref_sel_o,
  output logic        amp_off_o,
  output logic        cfg_err_o
);
  logic [2:0]       pins_s;
  logic             en_s, dat_s, sclk_s, sclk_fall;
  logic [DIV_W-1:0] sh_nxt;
  logic             band_stb, div_stb, tst_stb;
  cfg_t             cfg;

  tw_sync #(.W(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ser_en_i, ser_dat_i, ser_clk_i}),
    .q_o   (pins_s)
  );
  assign {en_s, dat_s, sclk_s} = pins_s;

  tw_frame_rx u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_s_i    (en_s),
    .dat_s_i   (dat_s),
    .sclk_s_i  (sclk_s),
    .fall_o    (sclk_fall),
    .sh_nxt_o  (sh_nxt),
    .band_stb_o(band_stb),
    .div_stb_o (div_stb),
    .tst_stb_o (tst_stb)
  );

  tw_cfg_latch u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sh_nxt_i  (sh_nxt),
    .band_stb_i(band_stb),
    .div_stb_i (div_stb),
    .tst_stb_i (tst_stb),
    .band_o    (band_o),
    .main_o    (main_cnt_o),
    .swal_o    (swal_cnt_o),
    .cfg_o     (cfg),
    .err_o     (cfg_err_o)
  );

  assign cp_hi_o     = cfg.cp_hi;
  assign test_mode_o = cfg.test_mode;
  assign ref_sel_o   = cfg.ref_sel;
  assign amp_off_o   = cfg.amp_off;
endmodule

// File: rtl/tw_cfg_chk.sv
module tw_cfg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_s,
  input logic       sclk_fall,
  input logic [3:0] band_o,
  input logic [9:0] main_cnt_o,
  input logic [4:0] swal_cnt_o,
  input logic       cp_hi_o,
  input logic [2:0] test_mode_o,
  input logic [1:0] ref_sel_o,
  input logic       amp_off_o,
  input logic       cfg_err_o
);
  a_r1_reset_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (band_o == 4'd0 && main_cnt_o == 10'd0 && swal_cnt_o == 5'd0 &&
                       cp_hi_o && test_mode_o == 3'b010 && ref_sel_o == 2'b00 &&
                       amp_off_o && !cfg_err_o));

  a_r2_idle_edges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_fall && !en_s) |=> ($stable(band_o) && $stable(main_cnt_o) &&
                              $stable(swal_cnt_o) && $stable(test_mode_o) &&
                              $stable(cfg_err_o)));

  a_r3_band_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(band_o) |-> $past(en_s));

  a_r6_ref_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(main_cnt_o) |-> ref_sel_o == 2'b00);

  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o);

  a_r9_err_keeps_cfg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_err_o) |-> ($stable(cp_hi_o) && $stable(test_mode_o) &&
                          $stable(ref_sel_o) && $stable(amp_off_o)));
endmodule

bind tw_cfg_reg tw_cfg_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_s       (en_s),
  .sclk_fall  (sclk_fall),
  .band_o     (band_o),
  .main_cnt_o (main_cnt_o),
  .swal_cnt_o (swal_cnt_o),
  .cp_hi_o    (cp_hi_o),
  .test_mode_o(test_mode_o),
  .ref_sel_o  (ref_sel_o),
  .amp_off_o  (amp_off_o),
  .cfg_err_o  (cfg_err_o)
);

// File: tb/tw_cfg_reg_tb.sv
module tw_cfg_reg_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ser_en = 1'b0, ser_dat = 1'b0, ser_clk = 1'b0;
  logic [3:0] band_o;
  logic [9:0] main_cnt_o;
  logic [4:0] swal_cnt_o;
  logic cp_hi_o, amp_off_o, cfg_err_o;
  logic [2:0] test_mode_o;
  logic [1:0] ref_sel_o;

  int checks = 0, errors = 0, quiet = 0;
  bit done = 0;

  // behavioural model state
  int m_cnt = 0;
  bit m_bits[$];
  logic [3:0] e_band = 4'd0;
  logic [9:0] e_main = 10'd0;
  logic [4:0] e_swal = 5'd0;
  logic e_cp = 1'b1, e_amp = 1'b1, e_err = 1'b0;
  logic [2:0] e_tm = 3'b010;
  logic [1:0] e_ref = 2'b00;

  always #5 clk = ~clk;

  tw_cfg_reg u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ser_en_i(ser_en), .ser_dat_i(ser_dat),
    .ser_clk_i(ser_clk), .band_o(band_o), .main_cnt_o(main_cnt_o),
    .swal_cnt_o(swal_cnt_o), .cp_hi_o(cp_hi_o), .test_mode_o(test_mode_o),
    .ref_sel_o(ref_sel_o), .amp_off_o(amp_off_o), .cfg_err_o(cfg_err_o)
  );

  function automatic logic [26:0] mk(input logic [3:0] b, input logic [9:0] m,
                                     input logic [4:0] s, input logic [7:0] t);
    return {b, m, s, t};
  endfunction

  function automatic int fld(input int first, input int n);
    int v = 0;
    for (int i = 0; i < n; i++) v = v * 2 + int'(m_bits[first - 1 + i]);
    return v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // model of one falling serial edge
  task automatic model_fall(input logic d);
    if (!ser_en || m_cnt >= 27) return;
    m_cnt++;
    m_bits.push_back(d);
    if (m_cnt == 4) e_band = 4'(fld(1, 4));
    if (m_cnt == 19) begin
      e_main = 10'(fld(5, 10));
      e_swal = 5'(fld(15, 5));
      e_ref  = 2'b00;
    end
    if (m_cnt == 27) begin
      if (m_bits[19]) begin
        e_cp  = 1'(fld(21, 1));
        e_tm  = 3'(fld(22, 3));
        e_ref = 2'(fld(25, 2));
        e_amp = 1'(fld(27, 1));
      end else e_err = 1'b1;
    end
  endtask

  task automatic pulse(input logic d);
    @(negedge clk); ser_dat = d; quiet = 0;
    repeat (3) @(negedge clk);
    ser_clk = 1'b1; quiet = 0;
    repeat (6) @(negedge clk);
    ser_clk = 1'b0; quiet = 0;
    model_fall(d);
    repeat (3) @(negedge clk);
  endtask

  task automatic frame(input logic [26:0] w, input int n, input int extra);
    @(negedge clk); ser_en = 1'b1; quiet = 0;
    m_cnt = 0; m_bits.delete();
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) pulse(w[26 - i]);
    for (int i = 0; i < extra; i++) pulse(1'b1);
    repeat (3) @(negedge clk);
    ser_en = 1'b0; quiet = 0;
    repeat (8) @(negedge clk);
  endtask

  // continuous comparison against the model once the bus has settled
  always @(posedge clk) begin
    #2;
    if (rst_ni && quiet >= 4) begin
      checks++;
      if ({band_o, main_cnt_o, swal_cnt_o, cp_hi_o, test_mode_o, ref_sel_o, amp_off_o, cfg_err_o} !==
          {e_band, e_main, e_swal, e_cp, e_tm, e_ref, e_amp, e_err}) begin
        errors++;
        $display("FAIL model compare: got %0h expected %0h",
          {band_o, main_cnt_o, swal_cnt_o, cp_hi_o, test_mode_o, ref_sel_o, amp_off_o, cfg_err_o},
          {e_band, e_main, e_swal, e_cp, e_tm, e_ref, e_amp, e_err});
      end
    end
    quiet++;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset values
    chk("R1 band", int'(band_o), 0);
    chk("R1 cp_hi", int'(cp_hi_o), 1);
    chk("R1 test_mode", int'(test_mode_o), 2);
    chk("R1 ref_sel", int'(ref_sel_o), 0);
    chk("R1 amp_off/err", int'({amp_off_o, cfg_err_o}), 2);

    // R3: 4-bit frame, first bit to band_o[3]
    frame(mk(4'b1000, 10'd0, 5'd0, 8'd0), 4, 0);
    chk("R3 band order", int'(band_o), 8);

    // R5: early drop after 12 bits
    frame(mk(4'b0101, 10'h3FF, 5'h1F, 8'd0), 12, 0);
    chk("R5 band updated", int'(band_o), 5);
    chk("R5 main kept", int'(main_cnt_o), 0);

    // R7: full frame, SI=1 CP=0 T=110 RS=11 OS=0
    frame(mk(4'b0011, 10'h155, 5'h0A, 8'b1011_0110), 27, 0);
    chk("R7 cp_hi", int'(cp_hi_o), 0);
    chk("R7 test_mode", int'(test_mode_o), 6);
    chk("R7 ref_sel", int'(ref_sel_o), 3);
    chk("R7 amp_off", int'(amp_off_o), 0);

    // R4/R6: 19-bit frame
    frame(mk(4'b0110, 10'h2A5, 5'h13, 8'hFF), 19, 0);
    chk("R4 main", int'(main_cnt_o), 'h2A5);
    chk("R4 swal", int'(swal_cnt_o), 'h13);
    chk("R6 ref forced", int'(ref_sel_o), 0);
    chk("R6 test kept", int'(test_mode_o), 6);

    // R8: extra edges beyond bit 27
    frame(mk(4'b1001, 10'h0F0, 5'h07, 8'b1100_1001), 27, 5);
    chk("R8 band", int'(band_o), 9);
    chk("R8 main", int'(main_cnt_o), 'h0F0);
    chk("R8 cfg", int'({cp_hi_o, test_mode_o, ref_sel_o, amp_off_o}), 'b1001001);

    // R2: serial clocks with enable low
    pulse(1'b0); pulse(1'b1); pulse(1'b0); pulse(1'b1);
    repeat (6) @(negedge clk);
    chk("R2 band idle", int'(band_o), 9);
    chk("R2 main idle", int'(main_cnt_o), 'h0F0);

    // R9: SI=0 full frame
    frame(mk(4'b1110, 10'h001, 5'h02, 8'b0011_1110), 27, 0);
    chk("R9 band", int'(band_o), 'hE);
    chk("R9 main", int'(main_cnt_o), 1);
    chk("R9 err", int'(cfg_err_o), 1);
    chk("R9 cfg kept", int'({cp_hi_o, test_mode_o, amp_off_o}), 'b100_11);
    frame(mk(4'b0001, 10'h002, 5'h03, 8'b1000_0000), 27, 0);
    chk("R9 err sticky", int'(cfg_err_o), 1);

    // R10: 2-bit frame then a 4-bit frame
    frame(mk(4'b1100, 10'd0, 5'd0, 8'd0), 2, 0);
    chk("R10 no commit", int'(band_o), 1);
    frame(mk(4'b0110, 10'd0, 5'd0, 8'd0), 4, 0);
    chk("R10 restart", int'(band_o), 6);

    repeat (10) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule